// File: doc/BRIEF.md
# I2C Slave Address Comparator

This block decides whether the address byte that opens an I2C transfer is meant for this device. Software loads an 8-bit own-address register. Bits 7:1 hold the seven-bit slave address. Bit 0 switches on recognition of the all-zero general call byte. The bit-level shifter reports each START or repeated START with a strobe. It then delivers each received byte with a valid strobe. Only the first byte after a START is compared.

A match raises three outputs. The first is an acknowledge request for the ninth clock. The second is a two-bit status code. The third is an interrupt request that stays high until software clears it. For an own-address match, the direction output carries the read/write bit of the byte. A general call always counts as a write. All outputs are registered and change on the clock edge after the byte strobe.

Top module: `i2c_addr_match`

## Requirements
- R1: After a synchronous reset, the own-address register is 00H and every output (`own_hit`, `gcall_hit`, `rd_dir`, `ack_req`, `irq`, `status`) is 0.
- R2: A cycle with `cfg_we` high loads `cfg_data` into the own-address register. The comparisons that follow use the new value.
- R3: When the compared byte has bits 7:1 equal to register bits 7:1, `own_hit` and `ack_req` go high on the next clock edge. This holds unless R4 applies.
- R4: When register bit 0 is 1 and the compared byte is 00H, `gcall_hit` and `ack_req` go high and `rd_dir` is 0. `own_hit` stays 0 even when the stored address is zero, because the general call takes precedence.
- R5: A 00H byte with register bit 0 clear matches only if the stored address is zero. Otherwise it gives no `gcall_hit`, no `ack_req` and no interrupt.
- R6: Only the first `rx_valid` after `bus_start` is compared. Later bytes leave every output unchanged.
- R7: `status` encodes the result: 00 = no match, 01 = own address with write, 10 = own address with read, 11 = general call. `rd_dir` equals bit 0 of the byte only on an own-address match, and is 0 otherwise.
- R8: A match sets `irq`. `irq` then stays high until a cycle with `irq_clr`. If a match and `irq_clr` fall in the same cycle, the set wins.
- R9: `bus_start` clears `own_hit`, `gcall_hit`, `rd_dir`, `ack_req` and `status` on the next edge. It leaves `irq` untouched.
- R10: A compared byte that matches nothing gives status 00 and `ack_req` 0, and leaves `irq` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the own-address register |
| cfg_data | input | 8 | Register value: bits 7:1 address, bit 0 general call enable |
| bus_start | input | 1 | START or repeated START seen on the bus |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Deserialized byte from the bus shifter |
| irq_clr | input | 1 | Software clear of the interrupt request |
| own_hit | output | 1 | First byte matched the own address |
| gcall_hit | output | 1 | First byte was an enabled general call |
| rd_dir | output | 1 | Read direction of a matched own-address byte |
| ack_req | output | 1 | Acknowledge the address byte |
| irq | output | 1 | Interrupt request |
| status | output | 2 | Result code (see R7) |

## Verification
The assertions assume that the shifter never raises `bus_start` and `rx_valid` in the same cycle. A START always comes before its first byte. The bench drives every strobe as a one-cycle pulse from its own tasks, so a START and a byte never coincide. Register writes are issued only between transfers, except in the one directed case that checks a write is seen by the next compare.

// File: rtl/i2c_acmp_pkg.sv
package i2c_acmp_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;

  typedef enum logic [1:0] {
    ST_NONE  = 2'b00,
    ST_OWN_W = 2'b01,
    ST_OWN_R = 2'b10,
    ST_GCALL = 2'b11
  } acmp_status_e;
endpackage

// File: rtl/acmp_own_reg.sv
module acmp_own_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/acmp_compare.sv
module acmp_compare #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] own_cfg,
  input  logic [W-1:0] rx,
  output logic         hit_own,
  output logic         hit_gc,
  output logic         dir
);
  localparam logic [W-1:0] GC_CODE = '0;

  logic addr_eq;

  always_comb begin
    addr_eq = (rx[W-1:1] == own_cfg[W-1:1]);
    hit_gc  = own_cfg[0] && (rx == GC_CODE);
    hit_own = addr_eq && !hit_gc;
    dir     = hit_own && rx[0];
  end
endmodule

// File: rtl/acmp_result.sv
module acmp_result
  import i2c_acmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_start,
  input  logic       rx_valid,
  input  logic       irq_clr,
  input  logic       hit_own,
  input  logic       hit_gc,
  input  logic       dir,
  output logic       own_hit,
  output logic       gcall_hit,
  output logic       rd_dir,
  output logic       ack_req,
  output logic       irq,
  output logic [1:0] status
);
  logic         armed;
  logic         take;
  logic         any_hit;
  acmp_status_e st_next;

  always_comb begin
    take    = armed && rx_valid && !bus_start;
    any_hit = hit_own || hit_gc;
    if (hit_gc)       st_next = ST_GCALL;
    else if (hit_own) st_next = dir ? ST_OWN_R : ST_OWN_W;
    else              st_next = ST_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      own_hit   <= 1'b0;
      gcall_hit <= 1'b0;
      rd_dir    <= 1'b0;
      ack_req   <= 1'b0;
      status    <= ST_NONE;
    end else if (bus_start) begin
      armed     <= 1'b1;
      own_hit   <= 1'b0;
      gcall_hit <= 1'b0;
      rd_dir    <= 1'b0;
      ack_req   <= 1'b0;
      status    <= ST_NONE;
    end else if (take) begin
      armed     <= 1'b0;
      own_hit   <= hit_own;
      gcall_hit <= hit_gc;
      rd_dir    <= dir;
      ack_req   <= any_hit;
      status    <= st_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                irq <= 1'b0;
    else if (take && any_hit) irq <= 1'b1;
    else if (irq_clr)       irq <= 1'b0;
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_acmp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [BYTE_W-1:0] cfg_data,
  input  logic              bus_start,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              irq_clr,
  output logic              own_hit,
  output logic              gcall_hit,
  output logic              rd_dir,
  output logic              ack_req,
  output logic              irq,
  output logic [1:0]        status
);
  logic [BYTE_W-1:0] own_cfg;
  logic              c_own, c_gc, c_dir;

  acmp_own_reg #(.W(BYTE_W), .RST_VAL(CFG_RST)) u_reg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_data), .q(own_cfg)
  );

  acmp_compare #(.W(BYTE_W)) u_cmp (
    .own_cfg(own_cfg), .rx(rx_byte),
    .hit_own(c_own), .hit_gc(c_gc), .dir(c_dir)
  );

  acmp_result u_res (
    .clk(clk), .rst(rst), .bus_start(bus_start), .rx_valid(rx_valid),
    .irq_clr(irq_clr), .hit_own(c_own), .hit_gc(c_gc), .dir(c_dir),
    .own_hit(own_hit), .gcall_hit(gcall_hit), .rd_dir(rd_dir),
    .ack_req(ack_req), .irq(irq), .status(status)
  );
endmodule

// File: rtl/acmp_checker.sv
module acmp_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_start,
  input logic       irq_clr,
  input logic       own_hit,
  input logic       gcall_hit,
  input logic       rd_dir,
  input logic       ack_req,
  input logic       irq,
  input logic [1:0] status
);
  // R4: general call and own match never both reported
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(own_hit && gcall_hit));

  // R7: direction only on an own-address match
  a_r7_dir_own: assert property (@(posedge clk) disable iff (rst)
    rd_dir |-> own_hit);

  // R7: general call code only with the general call flag
  a_r7_gc_code: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b11) |-> (gcall_hit && !rd_dir));

  // R3: acknowledge only for a match
  a_r3_ack_match: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> (own_hit || gcall_hit));

  // R8: interrupt holds without a clear
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  // R8: interrupt rises only with a match
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ack_req);

  // R9: a START clears the result
  a_r9_start_clear: assert property (@(posedge clk) disable iff (rst)
    bus_start |=> (!ack_req && status == 2'b00 && !own_hit && !gcall_hit));
endmodule

bind i2c_addr_match acmp_checker u_chk (
  .clk(clk), .rst(rst), .bus_start(bus_start), .irq_clr(irq_clr),
  .own_hit(own_hit), .gcall_hit(gcall_hit), .rd_dir(rd_dir),
  .ack_req(ack_req), .irq(irq), .status(status)
);

// File: tb/test_i2c_addr_match.sv
`timescale 1ns/1ps
module test_i2c_addr_match;
  logic clk = 1'b0;
  logic rst, cfg_we, bus_start, rx_valid, irq_clr;
  logic [7:0] cfg_data, rx_byte;
  logic own_hit, gcall_hit, rd_dir, ack_req, irq;
  logic [1:0] status;
  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_addr_match i_i2c_addr_match (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .bus_start(bus_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .irq_clr(irq_clr), .own_hit(own_hit), .gcall_hit(gcall_hit),
    .rd_dir(rd_dir), .ack_req(ack_req), .irq(irq), .status(status)
  );

  // {register, byte, status, dir}
  localparam logic [18:0] VEC [9] = '{
    {8'hA0, 8'hA0, 2'b01, 1'b0},  // R3 own write
    {8'hA0, 8'hA1, 2'b10, 1'b1},  // R7 own read
    {8'hA0, 8'hA2, 2'b00, 1'b0},  // R10 mismatch
    {8'hA1, 8'h00, 2'b11, 1'b0},  // R4 general call
    {8'hA0, 8'h00, 2'b00, 1'b0},  // R5 general call disabled
    {8'h01, 8'h00, 2'b11, 1'b0},  // R4 precedence over address zero
    {8'h00, 8'h00, 2'b01, 1'b0},  // R3 address zero, gc off
    {8'hFE, 8'hFF, 2'b10, 1'b1},  // R7 read at top address
    {8'h7F, 8'h7E, 2'b01, 1'b0}   // R3 with gc enable set
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_data = v; tick(); cfg_we = 1'b0;
  endtask

  task automatic start();
    bus_start = 1'b1; tick(); bus_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; tick(); rx_valid = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_up();
    end
  end

  initial begin
    rst = 1'b1; cfg_we = 0; cfg_data = 0; bus_start = 0;
    rx_valid = 0; rx_byte = 0; irq_clr = 0;
    tick(); tick(); rst = 1'b0; tick();

    // R1 reset state
    chk("R1 status", status, 2'b00);
    chk("R1 ack", ack_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flags", {own_hit, gcall_hit, rd_dir}, 3'b000);
    // R1 register resets to 00H: byte 01 matches address zero with read
    start(); send(8'h01);
    chk("R1 reg reset value", status, 2'b10);
    clr_irq();

    // vector table
    foreach (VEC[i]) begin
      logic [7:0] rv, bv; logic [1:0] es; logic ed;
      {rv, bv, es, ed} = VEC[i];
      wr_cfg(rv); clr_irq();
      start(); send(bv);
      chk("R7 status", status, es);
      chk("R7 dir", rd_dir, ed);
      chk("R3 ack", ack_req, es != 2'b00);
      chk("R4 gc", gcall_hit, es == 2'b11);
      chk("R8 irq", irq, es != 2'b00);
    end

    // R6: later bytes ignored
    wr_cfg(8'h40); clr_irq();
    start(); send(8'h12);
    chk("R10 no match", status, 2'b00);
    send(8'h40);
    chk("R6 second byte ignored status", status, 2'b00);
    chk("R6 second byte ignored irq", irq, 0);
    start(); send(8'h41);
    chk("R6 first byte read", status, 2'b10);
    send(8'h12);
    chk("R6 status kept", status, 2'b10);
    chk("R6 ack kept", ack_req, 1);

    // R9: start clears result but keeps irq
    start();
    chk("R9 status cleared", status, 2'b00);
    chk("R9 ack cleared", ack_req, 0);
    chk("R9 irq kept", irq, 1);

    // R10: mismatch leaves irq set
    send(8'h66);
    chk("R10 irq unchanged", irq, 1);
    chk("R10 ack", ack_req, 0);

    // R8: clear then set wins over clear
    clr_irq();
    chk("R8 cleared", irq, 0);
    start();
    rx_valid = 1'b1; rx_byte = 8'h40; irq_clr = 1'b1; tick();
    rx_valid = 1'b0; irq_clr = 1'b0;
    chk("R8 set beats clear", irq, 1);
    tick(); tick();
    chk("R8 holds", irq, 1);

    // R2: write then compare uses new value
    wr_cfg(8'h5A); clr_irq();
    start(); send(8'h40);
    chk("R2 old address gone", status, 2'b00);
    start(); send(8'h5A);
    chk("R2 new address write", status, 2'b01);

    // R5: 00H with gc clear, nonzero address
    start(); send(8'h00);
    chk("R5 no gc", gcall_hit, 0);
    chk("R5 no ack", ack_req, 0);

    // R1: reset mid-state
    rst = 1'b1; tick(); rst = 1'b0; tick();
    chk("R1 reset irq", irq, 0);
    chk("R1 reset status", status, 2'b00);

    done = 1'b1;
    finish_up();
  end
endmodule